// File: doc/BRIEF.md
# MSI capability register set and message generator

This block holds the three registers that describe message-signalled interrupts for one function: a 16-bit control word, a 64-bit message address and a 32-bit message data word. Software reaches them through a plain word-indexed read/write port. Every interrupt is sent as a single posted memory write that carries all of its routing and delivery information. There are no interrupt lines and no acknowledge cycles.

Each bit of `irq_req` is one interrupt source. A rising edge on a source marks it pending. While messaging is enabled, the pending sources are turned one at a time into write requests on a valid/ready output. The address comes from the programmed destination fields, and the data word comes from the programmed vector and delivery fields. When more than one message is granted, the low bits of the vector are replaced by the source number. Edges that arrive while messaging is off are held until it is switched on.

Top module: `msi_msg_gen`

## Requirements
- R1: The control word reads back as follows. Bit 0 is the enable and is writable. Bits 3:1 hold the message-count capability, which is the parameter `CAP_CODE` and cannot be written. Bits 6:4 hold the granted message count. Bit 7 reads 1 when `ADDR64` is set. Bits 31:8 read zero. After reset the enable and the granted count are both zero.
- R2: Message counts are coded as n, meaning 2^n messages, for n from 0 to 5. Codes 6 and 7 are reserved. A write to the granted-count field with a code above `CAP_CODE`, or with a reserved code, stores `CAP_CODE` instead.
- R3: The low address word has the following fields:
  - Bits 31:20 always read 0xFEE.
  - Bits 19:12 hold the destination id.
  - Bit 3 is the redirection hint.
  - Bit 2 is the destination mode, where 0 means physical and 1 means logical.
  - All other bits read zero.
  The high address word always reads zero and ignores writes.
- R4: The data word stores bits 7:0 (vector), bits 10:8 (delivery mode), bit 14 (level, 1 = assert) and bit 15 (trigger mode, 1 = level). All other bits read zero.
- R5: Register index 0 selects control, 1 selects the low address word, 2 selects the high address word and 3 selects the data word. A read returns its value in the same cycle as the index.
- R6: No request leaves while the enable is 0. Edges seen while disabled stay pending and are sent after the enable is set.
- R7: When the granted-count code is k, the low k bits of the outgoing vector are replaced by the source number. All other data bits equal the stored data word.
- R8: At most one request is outstanding at a time. Among the pending sources, the lowest-numbered one is sent first.
- R9: A source's pending bit clears in the cycle where valid and ready are both high. Repeated edges on a source that is already pending produce only one request.
- R10: The outgoing address is 64 bits wide. Bits 63:32 are zero, bits 31:20 are 0xFEE, and the destination, hint and mode fields sit as in R3. The address and data stay constant while valid is high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index (R5) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| irq_req | input | NUM_SRC | Per-source interrupt request; a rising edge marks the source pending |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted |
| msg_addr | output | 64 | Write address |
| msg_data | output | 32 | Write data |

## Verification
The hardest situation to reach from the ports is several sources pending at once, together with a stalled output and repeated edges on a source that is already pending. The stimulus holds `msg_ready` low and pulses a group of sources in one cycle, then releases ready and checks the drain order. It also pulses one source twice while the enable is off, then switches the enable on and checks that exactly one message comes out. Clamping is covered by writing a reserved code and an over-capable code to the granted-count field and reading the result back.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [11:0] MSI_WINDOW = 12'hFEE;

  typedef enum logic [1:0] {
    IDX_CTRL    = 2'd0,
    IDX_ADDR_LO = 2'd1,
    IDX_ADDR_HI = 2'd2,
    IDX_DATA    = 2'd3
  } reg_idx_e;

  // Keep a granted count legal: reserved codes or codes above the capability fall back to it
  function automatic logic [2:0] clamp_grant(input logic [2:0] req, input logic [2:0] cap);
    if (req > cap || req > 3'd5) return cap;
    return req;
  endfunction

  // Substitute the low 'code' bits of the vector with the source number
  function automatic logic [7:0] merge_vector(input logic [7:0] vec, input logic [2:0] code,
                                              input logic [7:0] src);
    logic [7:0] mask;
    mask = (8'd1 << code) - 8'd1;
    return (vec & ~mask) | (src & mask);
  endfunction
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_pkg::*;
#(
  parameter logic [2:0] CAP_CODE = 3'd2,
  parameter bit         ADDR64   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [1:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        msi_en,
  output logic [2:0]  grant_code,
  output logic [63:0] dest_addr,
  output logic [31:0] base_data
);
  logic       en_q, en_d;
  logic [2:0] grant_q, grant_d;
  logic [7:0] dest_q, dest_d;
  logic       hint_q, hint_d, dmode_q, dmode_d;
  logic [7:0] vec_q, vec_d;
  logic [2:0] dlv_q, dlv_d;
  logic       lvl_q, lvl_d, tmode_q, tmode_d;

  logic [15:0] ctrl_word;
  logic [31:0] addr_lo_word, data_word;

  assign ctrl_word    = {8'h00, ADDR64, grant_q, CAP_CODE, en_q};
  assign addr_lo_word = {MSI_WINDOW, dest_q, 8'h00, hint_q, dmode_q, 2'b00};
  assign data_word    = {16'h0000, tmode_q, lvl_q, 3'b000, dlv_q, vec_q};

  always_comb begin
    en_d = en_q; grant_d = grant_q;
    dest_d = dest_q; hint_d = hint_q; dmode_d = dmode_q;
    vec_d = vec_q; dlv_d = dlv_q; lvl_d = lvl_q; tmode_d = tmode_q;
    if (wr) begin
      unique case (reg_idx_e'(idx))
        IDX_CTRL: begin
          en_d    = wdata[0];
          grant_d = clamp_grant(wdata[6:4], CAP_CODE);
        end
        IDX_ADDR_LO: begin
          dest_d  = wdata[19:12];
          hint_d  = wdata[3];
          dmode_d = wdata[2];
        end
        IDX_DATA: begin
          vec_d   = wdata[7:0];
          dlv_d   = wdata[10:8];
          lvl_d   = wdata[14];
          tmode_d = wdata[15];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; grant_q <= 3'd0;
      dest_q <= 8'h00; hint_q <= 1'b0; dmode_q <= 1'b0;
      vec_q <= 8'h00; dlv_q <= 3'd0; lvl_q <= 1'b0; tmode_q <= 1'b0;
    end else if (wr) begin
      en_q <= en_d; grant_q <= grant_d;
      dest_q <= dest_d; hint_q <= hint_d; dmode_q <= dmode_d;
      vec_q <= vec_d; dlv_q <= dlv_d; lvl_q <= lvl_d; tmode_q <= tmode_d;
    end
  end

  always_comb begin
    unique case (reg_idx_e'(idx))
      IDX_CTRL:    rdata = {16'h0000, ctrl_word};
      IDX_ADDR_LO: rdata = addr_lo_word;
      IDX_ADDR_HI: rdata = 32'h0000_0000;
      default:     rdata = data_word;
    endcase
  end

  assign msi_en     = en_q;
  assign grant_code = grant_q;
  assign dest_addr  = {32'h0000_0000, addr_lo_word};
  assign base_data  = data_word;

  p_grant_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q <= CAP_CODE) && (grant_q <= 3'd5));
  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 2'd0 && (wdata[6:4] > CAP_CODE || wdata[6:4] > 3'd5)) |=> (grant_code == CAP_CODE));
endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq,
  input  logic               msi_en,
  input  logic               busy,
  input  logic               done,
  input  logic [SRC_W-1:0]   done_src,
  output logic               launch,
  output logic [SRC_W-1:0]   sel
);
  logic [NUM_SRC-1:0] irq_q, pend_q, pend_d, rise, clr;

  assign rise = irq & ~irq_q;

  always_comb begin
    clr = '0;
    if (done) clr[done_src] = 1'b1;
    // a fresh edge in the clearing cycle wins so it is not lost
    pend_d = (pend_q & ~clr) | rise;
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_q[i]) sel = SRC_W'(i);
  end

  assign launch = msi_en && !busy && (|pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq;
      pend_q <= pend_d;
    end
  end

  p_launch_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> pend_q[sel]);
  p_clear_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rise[done_src]) |=> !pend_q[$past(done_src)]);
endmodule

// File: rtl/msi_tx.sv
module msi_tx
  import msi_pkg::*;
#(
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [SRC_W-1:0] sel,
  input  logic             msi_en,
  input  logic [2:0]       grant_code,
  input  logic [63:0]      dest_addr,
  input  logic [31:0]      base_data,
  input  logic             ready,
  output logic             valid,
  output logic [63:0]      addr,
  output logic [31:0]      data,
  output logic [SRC_W-1:0] src
);
  logic             valid_q, valid_d;
  logic [63:0]      addr_q;
  logic [31:0]      data_q, data_d;
  logic [SRC_W-1:0] src_q;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready) valid_d = 1'b0;
    if (launch)           valid_d = 1'b1;
    data_d = {base_data[31:8], merge_vector(base_data[7:0], grant_code, 8'(sel))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      src_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (launch) begin
        addr_q <= dest_addr;
        data_q <= data_d;
        src_q  <= sel;
      end
    end
  end

  assign valid = valid_q;
  assign addr  = addr_q;
  assign data  = data_q;
  assign src   = src_q;

  p_no_send_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(msi_en));
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));
  p_addr_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (addr[63:32] == 32'h0 && addr[31:20] == MSI_WINDOW && addr[1:0] == 2'b00));
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen #(
  parameter int         NUM_SRC  = 4,
  parameter logic [2:0] CAP_CODE = 3'd2,
  parameter bit         ADDR64   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_idx,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             msi_en, launch;
  logic [2:0]       grant_code;
  logic [63:0]      dest_addr;
  logic [31:0]      base_data;
  logic [SRC_W-1:0] sel, cur_src;

  msi_cap_regs #(.CAP_CODE(CAP_CODE), .ADDR64(ADDR64)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .rdata(reg_rdata), .msi_en(msi_en), .grant_code(grant_code),
    .dest_addr(dest_addr), .base_data(base_data)
  );

  msi_pend_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .irq(irq_req), .msi_en(msi_en), .busy(msg_valid),
    .done(msg_valid && msg_ready), .done_src(cur_src), .launch(launch), .sel(sel)
  );

  msi_tx #(.SRC_W(SRC_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .launch(launch), .sel(sel), .msi_en(msi_en),
    .grant_code(grant_code), .dest_addr(dest_addr), .base_data(base_data),
    .ready(msg_ready), .valid(msg_valid), .addr(msg_addr), .data(msg_data), .src(cur_src)
  );

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);
endmodule

// File: tb/msi_msg_gen_tb.sv
module msi_msg_gen_tb_top;
  localparam int NUM_SRC = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reg_wr = 1'b0;
  logic [1:0]         reg_idx = 2'd0;
  logic [31:0]        reg_wdata = 32'h0;
  logic [31:0]        reg_rdata;
  logic [NUM_SRC-1:0] irq_req = '0;
  logic               msg_valid;
  logic               msg_ready = 1'b1;
  logic [63:0]        msg_addr;
  logic [31:0]        msg_data;

  int checks = 0;
  int errors = 0;
  logic [95:0] exp_q[$];

  // bench copies of programmed register contents
  logic [7:0]  sw_dest = 8'h00;
  logic        sw_hint = 1'b0, sw_dmode = 1'b0;
  logic [31:0] sw_data = 32'h0;
  logic [2:0]  sw_grant = 3'd0;

  always #5 clk = ~clk;

  msi_msg_gen #(.NUM_SRC(NUM_SRC), .CAP_CODE(3'd2), .ADDR64(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] idx, input logic [31:0] val);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [1:0] idx, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    reg_idx = idx;
    #2;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  // driver side of the scoreboard: predicted write for a source
  task automatic expect_msg(input int src);
    logic [7:0]  mask, vec;
    logic [63:0] a;
    logic [31:0] d;
    mask = (8'd1 << sw_grant) - 8'd1;
    vec  = (sw_data[7:0] & ~mask) | (8'(src) & mask);
    a = {32'h0, 12'hFEE, sw_dest, 8'h00, sw_hint, sw_dmode, 2'b00};
    d = {sw_data[31:8] & 24'h00C7, vec};
    exp_q.push_back({a, d});
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] bits);
    @(posedge clk); #1;
    irq_req = bits;
    @(posedge clk); #1;
    irq_req = '0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 300) begin
      @(posedge clk); n++;
    end
    repeat (8) @(posedge clk);
    check(req, 64'(exp_q.size()), 64'd0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected write actual=%h_%h expected=none", msg_addr, msg_data);
      end else begin
        logic [95:0] e;
        e = exp_q.pop_front();
        if ({msg_addr, msg_data} !== e) begin
          errors++;
          $display("FAIL R7/R8/R10 message actual=%h_%h expected=%h_%h",
                   msg_addr, msg_data, e[95:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values, R5 indexing
    reg_check(2'd0, 32'h0000_0084, "R1 reset control");
    #1 check("R1 reset valid", 64'(msg_valid), 64'd0);

    // R3 address fields, high word ignores writes
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_check(2'd1, 32'hFEEF_F00C, "R3 addr lo all ones");
    reg_write(2'd2, 32'hFFFF_FFFF);
    reg_check(2'd2, 32'h0000_0000, "R3 addr hi ignored");
    reg_write(2'd1, 32'h0000_5004);
    sw_dest = 8'h05; sw_hint = 1'b0; sw_dmode = 1'b1;
    reg_check(2'd1, 32'hFEE0_5004, "R3 addr lo dest");

    // R4 data fields
    reg_write(2'd3, 32'hFFFF_FFFF);
    reg_check(2'd3, 32'h0000_C7FF, "R4 data all ones");
    reg_write(2'd3, 32'h0000_4031);
    sw_data = 32'h0000_4031;
    reg_check(2'd3, 32'h0000_4031, "R4 data vector");

    // R2 clamping
    reg_write(2'd0, 32'h0000_0070);
    reg_check(2'd0, 32'h0000_00A4, "R2 reserved code clamps");
    reg_write(2'd0, 32'h0000_0030);
    reg_check(2'd0, 32'h0000_00A4, "R2 over capability clamps");
    reg_write(2'd0, 32'h0000_0010);
    reg_check(2'd0, 32'h0000_0094, "R2 legal code kept");
    reg_write(2'd0, 32'hFFFF_FF00);
    reg_check(2'd0, 32'h0000_0084, "R1 reserved bits zero");

    // R6/R9: two edges on source 2 while disabled
    pulse(4'b0100);
    pulse(4'b0100);
    repeat (6) @(posedge clk);
    #1 check("R6 no write while disabled", 64'(msg_valid), 64'd0);
    sw_grant = 3'd2;
    expect_msg(2);
    reg_write(2'd0, 32'h0000_0021);
    drain("R6 R9 single held message");

    // R8 order with stalled output
    msg_ready = 1'b0;
    expect_msg(0); expect_msg(1); expect_msg(3);
    pulse(4'b1011);
    repeat (6) @(posedge clk);
    #1 check("R8 one outstanding while stalled", 64'(msg_valid), 64'd1);
    check("R10 stalled data lowest source", 64'(msg_data), 64'h0000_4030);
    msg_ready = 1'b1;
    drain("R8 ordered drain");

    // R7 with one and two messages granted
    reg_write(2'd0, 32'h0000_0001);
    sw_grant = 3'd0;
    expect_msg(3);
    pulse(4'b1000);
    drain("R7 single message vector");
    reg_write(2'd0, 32'h0000_0011);
    sw_grant = 3'd1;
    expect_msg(2);
    pulse(4'b0100);
    drain("R7 two message vector");

    #1 check("R9 idle after drain", 64'(msg_valid), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule